// File: doc/BRIEF.md
# Host Handshake and Interrupt Controller

This block sits between a host port and an on-chip control processor. It tracks each host access, classifies it as a read or a write, a command or a data word, or a status read, and pulses a completion strobe one clock after the host ends the access. The block holds a ready line low for the host until the transaction has been dealt with. Status reads never hold it low.

A command from the host interrupts the processor. Data words are counted against a remaining-word count that the processor loads once it has decoded a command. Only the last word of a multi-word transfer interrupts the processor. Earlier words release ready on their own. A processor write to the interface registers acknowledges the interrupt, clears the command-pending flag and restores ready. Host inputs are assumed to be already synchronous to `clk_i`.

Top module: `host_handshake_ctrl`

## Requirements
- R1: After asynchronous reset, host_rdy_o=1, cp_irq_o=0, cmd_pend_o=0, xfer_done_o=0 and words_left_o=0.
- R2: xfer_done_o is high for exactly one cycle. It rises on the first clock edge that samples host_sel_i low after it was sampled high.
- R3: The first edge that samples host_sel_i high latches host_wr_i, host_cmd_i and host_stat_i into txn_wr_o, txn_cmd_o and txn_stat_o. They hold until the next access starts.
- R4: While host_sel_i is high with host_stat_i=0, host_rdy_o is 0. A status read (host_stat_i=1) leaves host_rdy_o unchanged.
- R5: On the edge after the xfer_done_o cycle of a command access (host_cmd_i=1, host_stat_i=0) with irq_en_i=1, cp_irq_o goes to 1 and host_rdy_o stays 0. A command write (host_wr_i=1) also sets cmd_pend_o.
- R6: A data write raises cp_irq_o when words_left_o is 0 or 1 at completion. A data read raises it only when words_left_o is 0.
- R7: A data word that raises no interrupt re-asserts host_rdy_o on the edge after xfer_done_o. Each data word decrements a non-zero words_left_o by one.
- R8: No interrupt is raised when irq_en_i=0 or the access was a status read.
- R9: cp_wr_i sampled high clears cp_irq_o and cmd_pend_o and sets host_rdy_o on that edge.
- R10: cp_cnt_ld_i sampled high loads cp_cnt_i into words_left_o on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | Host access in progress |
| host_wr_i | input | 1 | Host access is a write |
| host_cmd_i | input | 1 | Host access targets the command register |
| host_stat_i | input | 1 | Host access is a status read |
| irq_en_i | input | 1 | Interrupt enable |
| cp_wr_i | input | 1 | Processor write to interface registers (acknowledge) |
| cp_cnt_ld_i | input | 1 | Load remaining-word count |
| cp_cnt_i | input | CNT_W | Remaining-word count value |
| host_rdy_o | output | 1 | Ready to host |
| cp_irq_o | output | 1 | Interrupt to processor |
| cmd_pend_o | output | 1 | Command-pending flag |
| xfer_done_o | output | 1 | One-cycle completion strobe |
| words_left_o | output | CNT_W | Remaining-word count |
| txn_wr_o | output | 1 | Latched write flag |
| txn_cmd_o | output | 1 | Latched command flag |
| txn_stat_o | output | 1 | Latched status-read flag |

## Verification
The assertions assume that the host starts a non-status access only while ready is high. They also assume that an acknowledge or count load never lands on the same edge as a completion strobe, and that the host type inputs are stable for the whole access. The stimulus follows these rules. Each access runs to completion, and the bench waits for the effects to settle before it issues the next acknowledge or load. Status reads are the only accesses made while an interrupt is outstanding.

// File: rtl/hhs_pkg.sv
package hhs_pkg;
  typedef struct packed {
    logic wr;
    logic cmd;
    logic stat;
  } txn_t;
endpackage

// File: rtl/hhs_txn_capture.sv
module hhs_txn_capture
  import hhs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  txn_t txn_i,
  output txn_t txn_o,
  output logic start_o,
  output logic done_o
);
  logic act_q, done_q;
  txn_t txn_q;

  assign start_o = sel_i & ~act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      txn_q  <= '0;
    end else begin
      act_q  <= sel_i;
      done_q <= act_q & ~sel_i;
      if (start_o) txn_q <= txn_i;
    end
  end

  assign txn_o  = txn_q;
  assign done_o = done_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(sel_i, 2) && !$past(sel_i));
  // R3
  txn_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> txn_q == $past(txn_i));
endmodule

// File: rtl/hhs_word_cnt.sv
module hhs_word_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (ld_i)                 cnt_q <= ld_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign cnt_o = cnt_q;

  // R10
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_q == $past(ld_val_i));
  // R7
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !ld_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - ONE);
endmodule

// File: rtl/hhs_irq_ctrl.sv
module hhs_irq_ctrl
  import hhs_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_hold_i,
  input  logic             done_i,
  input  txn_t             txn_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             irq_en_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic             pend_o,
  output logic             rdy_o,
  output logic             dec_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic irq_q, pend_q, rdy_q;
  logic last_word, fire;

  // write completes on count 1 or 0, read only on 0
  assign last_word = txn_i.wr ? (cnt_i <= ONE) : (cnt_i == '0);
  assign fire      = done_i & irq_en_i & ~txn_i.stat & (txn_i.cmd | last_word);
  assign dec_o     = done_i & ~txn_i.stat & ~txn_i.cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
      rdy_q  <= 1'b1;
    end else if (ack_i) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
      rdy_q  <= 1'b1;
    end else begin
      if (start_hold_i) rdy_q <= 1'b0;
      if (done_i && !txn_i.stat) begin
        if (txn_i.cmd && txn_i.wr) pend_q <= 1'b1;
        if (fire)                  irq_q  <= 1'b1;
        else if (!txn_i.cmd)       rdy_q  <= 1'b1;
      end
    end
  end

  assign irq_o  = irq_q;
  assign pend_o = pend_q;
  assign rdy_o  = rdy_q;

  // R9
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_q && !pend_q && rdy_q);
  // R8
  no_irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !ack_i && !irq_q && (!irq_en_i || txn_i.stat) |=> !irq_q);
  // R5
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(done_i) && $past(irq_en_i));
  // R5
  irq_holds_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !ack_i |=> !rdy_q);
endmodule

// File: rtl/host_handshake_ctrl.sv
module host_handshake_ctrl
  import hhs_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_sel_i,
  input  logic             host_wr_i,
  input  logic             host_cmd_i,
  input  logic             host_stat_i,
  input  logic             irq_en_i,
  input  logic             cp_wr_i,
  input  logic             cp_cnt_ld_i,
  input  logic [CNT_W-1:0] cp_cnt_i,
  output logic             host_rdy_o,
  output logic             cp_irq_o,
  output logic             cmd_pend_o,
  output logic             xfer_done_o,
  output logic [CNT_W-1:0] words_left_o,
  output logic             txn_wr_o,
  output logic             txn_cmd_o,
  output logic             txn_stat_o
);
  txn_t             txn_in, txn_q;
  logic             start, done, rdy_q, dec;
  logic [CNT_W-1:0] cnt;

  assign txn_in = '{wr: host_wr_i, cmd: host_cmd_i, stat: host_stat_i};

  hhs_txn_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (host_sel_i),
    .txn_i   (txn_in),
    .txn_o   (txn_q),
    .start_o (start),
    .done_o  (done)
  );

  hhs_word_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (cp_cnt_ld_i),
    .ld_val_i (cp_cnt_i),
    .dec_i    (dec),
    .cnt_o    (cnt)
  );

  hhs_irq_ctrl #(.CNT_W(CNT_W)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_hold_i (start & ~host_stat_i),
    .done_i       (done),
    .txn_i        (txn_q),
    .cnt_i        (cnt),
    .irq_en_i     (irq_en_i),
    .ack_i        (cp_wr_i),
    .irq_o        (cp_irq_o),
    .pend_o       (cmd_pend_o),
    .rdy_o        (rdy_q),
    .dec_o        (dec)
  );

  // hold ready low from the first cycle of a non-status access
  assign host_rdy_o   = rdy_q & ~(host_sel_i & ~host_stat_i);
  assign xfer_done_o  = done;
  assign words_left_o = cnt;
  assign txn_wr_o     = txn_q.wr;
  assign txn_cmd_o    = txn_q.cmd;
  assign txn_stat_o   = txn_q.stat;

  // R4
  stat_keeps_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_sel_i && host_stat_i && !cp_wr_i && !done |=> rdy_q == $past(rdy_q));
endmodule

// File: tb/host_handshake_ctrl_tb.sv
module host_handshake_ctrl_tb;
  localparam int CNT_W = 2;
  localparam logic [8:0] M_RDY = 9'h100, M_IRQ = 9'h080, M_PEND = 9'h040,
                         M_DONE = 9'h020, M_CNT = 9'h018, M_TXN = 9'h007;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, wr = 0, cmd = 0, stat = 0, en = 0, ack = 0, ld = 0;
  logic [CNT_W-1:0] ld_val = '0;
  logic rdy, irq, pend, done_s, t_wr, t_cmd, t_stat;
  logic [CNT_W-1:0] left;

  host_handshake_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_sel_i(sel), .host_wr_i(wr),
    .host_cmd_i(cmd), .host_stat_i(stat), .irq_en_i(en), .cp_wr_i(ack),
    .cp_cnt_ld_i(ld), .cp_cnt_i(ld_val), .host_rdy_o(rdy), .cp_irq_o(irq),
    .cmd_pend_o(pend), .xfer_done_o(done_s), .words_left_o(left),
    .txn_wr_o(t_wr), .txn_cmd_o(t_cmd), .txn_stat_o(t_stat)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int         cyc;
    logic [8:0] exp;
    logic [8:0] msk;
    string      req;
  } item_t;
  item_t sb[$];

  int cyc = 0, n_chk = 0, n_err = 0;
  bit finished = 0;
  logic m_rdy = 1, m_irq = 0, m_pend = 0;
  int m_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [8:0] pack(logic r, logic i, logic p, logic d,
                                      int c, logic w, logic k, logic s);
    return {r, i, p, d, 2'(c), w, k, s};
  endfunction

  task automatic push(int c, logic [8:0] e, logic [8:0] m, string r);
    item_t it;
    it.cyc = c; it.exp = e; it.msk = m; it.req = r;
    sb.push_back(it);
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      item_t it;
      logic [8:0] obs;
      it  = sb.pop_front();
      obs = {rdy, irq, pend, done_s, left, t_wr, t_cmd, t_stat};
      n_chk++;
      if (it.cyc != cyc || (obs & it.msk) != (it.exp & it.msk)) begin
        n_err++;
        $display("FAIL %s: cyc=%0d actual=%b expected=%b mask=%b",
                 it.req, cyc, obs, it.exp, it.msk);
      end
    end
  end

  task automatic host_txn(logic w, logic k, logic s, int len);
    int kc, dc;
    logic fire;
    @(posedge clk); #1;
    sel = 1; wr = w; cmd = k; stat = s;
    kc = cyc;
    push(kc, pack(s ? m_rdy : 1'b0, 0, 0, 0, 0, 0, 0, 0), M_RDY, "R4 ready during access");
    push(kc + 1, pack(0, 0, 0, 0, 0, w, k, s), M_TXN, "R3 type latched");
    if (!s) m_rdy = 0;
    repeat (len) @(posedge clk);
    #1; sel = 0;
    dc = cyc;
    push(dc + 1, pack(0, 0, 0, 1, 0, 0, 0, 0), M_DONE, "R2 done pulse high");
    if (!s) begin
      fire = en && (k || (w ? m_cnt <= 1 : m_cnt == 0));
      if (!k && m_cnt > 0) m_cnt--;
      if (k && w) m_pend = 1;
      if (fire) m_irq = 1;
      else if (!k) m_rdy = 1;
    end
    push(dc + 2, pack(m_rdy, m_irq, m_pend, 0, m_cnt, 0, 0, 0),
         M_RDY | M_IRQ | M_PEND | M_DONE | M_CNT, "R5 R6 R7 R8 R2 completion effects");
    repeat (3) @(posedge clk);
  endtask

  task automatic cp_ack();
    @(posedge clk); #1;
    ack = 1;
    m_irq = 0; m_pend = 0; m_rdy = 1;
    push(cyc + 1, pack(1, 0, 0, 0, 0, 0, 0, 0), M_RDY | M_IRQ | M_PEND, "R9 ack clears");
    @(posedge clk); #1; ack = 0;
    @(posedge clk);
  endtask

  task automatic cp_load(int v);
    @(posedge clk); #1;
    ld = 1; ld_val = 2'(v);
    m_cnt = v;
    push(cyc + 1, pack(0, 0, 0, 0, v, 0, 0, 0), M_CNT, "R10 count load");
    @(posedge clk); #1; ld = 0;
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    push(cyc, pack(1, 0, 0, 0, 0, 0, 0, 0), 9'h1F8, "R1 reset state");
    @(posedge clk); #1; rst_n = 1;
    en = 1;
    // command write interrupts, sets pending
    host_txn(1, 1, 0, 2);
    cp_ack();
    // two-word data write
    cp_load(2);
    host_txn(1, 0, 0, 1);
    host_txn(1, 0, 0, 3);
    cp_ack();
    // two-word data read
    cp_load(1);
    host_txn(0, 0, 0, 1);
    host_txn(0, 0, 0, 2);
    cp_ack();
    // status read: no stall, no interrupt
    host_txn(0, 0, 1, 1);
    // masked command read
    en = 0;
    host_txn(0, 1, 0, 1);
    cp_ack();
    // single data write, then status read while interrupt outstanding
    en = 1;
    host_txn(1, 0, 0, 1);
    host_txn(0, 0, 1, 2);
    cp_ack();
    // four-word read, count 3 down to 0
    cp_load(3);
    for (int i = 0; i < 4; i++) host_txn(0, 0, 0, 1);
    cp_ack();
    // masked data write at count 0 releases ready itself
    en = 0;
    host_txn(1, 0, 0, 1);
    repeat (4) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule